// File: doc/BRIEF.md
# Debug Message Sequencer with DMA Handshake

This block sits next to the acceptance path of a CAN receiver. For every frame that matched a filter element, it looks at that element's configuration code. A match counts as a debug match only when the code marks the element for debug handling. For each debug match, the block decides whether to store the frame. It then issues a store command with the receive-buffer index taken from the filter element.

Three debug messages, called A, B and C, must arrive in that order. The block stores each one into its own buffer slot, normally three consecutive slots such as 61, 62 and 63. When message C reports that its write has completed, the block raises a DMA request. While that request is up, the block issues no further debug stores, so the three buffer words stay intact until the DMA unit acknowledges.

A message that arrives out of order restarts the sequence. A 2-bit status output reports how far the current set has progressed.

Top module: `dbgseq_top`

## Requirements
- R1: While reset is asserted, and after it is released, store_en, dma_req, new_data_set and rx_irq_set are 0 and dbg_status is 00. The internal reset is released on the second rising clock edge after rst_n goes high.
- R2: A match whose configuration code match_cfg is not 3'b111 produces no store and does not change the status.
- R3: A debug match with tag 00 (message A) arriving while idle raises store_en for exactly one cycle, starting the cycle after the match is sampled. In that cycle store_idx equals match_idx, and dbg_status becomes 01.
- R4: A debug match with tag 01 (message B) while the status is 01 is stored and moves the status to 10. A debug match with tag 10 (message C) while in that A-then-B state is stored, and the status stays 10 until the write of C completes.
- R5: A store_done pulse sampled while C's write is outstanding raises dma_req in the following cycle and sets dbg_status to 11. A store_done at any other time has no effect.
- R6: While C's write is outstanding, and while dma_req is high, debug matches produce no store and do not change the status.
- R7: dma_ack sampled while dma_req is high clears dma_req and returns dbg_status to 00 in the following cycle. dma_ack at any other time has no effect.
- R8: A message A arriving out of sequence, while the status is 01 or 10, is stored and restarts the sequence with dbg_status 01.
- R9: A message B or C arriving out of sequence is not stored and returns dbg_status to 00. A debug match with tag 11 is ignored.
- R10: new_data_set and rx_irq_set stay 0, including in the cycles where store_en is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| match_vld | input | 1 | Filter match strobe, one cycle per matched frame |
| match_cfg | input | 3 | Configuration code of the matching filter element |
| match_tag | input | 2 | Message tag from the filter element (00 A, 01 B, 10 C) |
| match_idx | input | 6 | Receive-buffer index from the filter element |
| store_done | input | 1 | Pulse: the last issued store has been written |
| dma_ack | input | 1 | DMA transfer finished |
| store_en | output | 1 | Store command for the current frame |
| store_idx | output | 6 | Target buffer index for store_en |
| new_data_set | output | 1 | Buffer new-data flag set request (always 0 for debug stores) |
| rx_irq_set | output | 1 | Buffer-receive interrupt set request (always 0 for debug stores) |
| dma_req | output | 1 | DMA request; the debug slots are protected while high |
| dbg_status | output | 2 | 00 idle, 01 A held, 10 A and B held, 11 set complete with DMA pending |

## Verification
Every result is registered, so it is due exactly one cycle after the rising edge that samples its cause:
- store_en, store_idx and dbg_status follow a sampled match one cycle later.
- dma_req rises one cycle after the store_done that completes C.
- dma_req falls one cycle after dma_ack.

The bench drives inputs on the falling edge. A behavioural model advances on each rising edge, and on the next falling edge the bench compares every output against that model. Each compare lines up with the cycle in which the design's registers have updated. After rst_n rises, the bench waits for the two-edge reset release before it starts sequencing stimulus.

// File: rtl/dbgseq_pkg.sv
package dbgseq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_HAVEA = 3'd1,
    ST_HAVEB = 3'd2,
    ST_CWAIT = 3'd3,
    ST_PEND  = 3'd4
  } seq_state_t;

  localparam logic [1:0] TAG_A = 2'b00;
  localparam logic [1:0] TAG_B = 2'b01;
  localparam logic [1:0] TAG_C = 2'b10;

  localparam logic [1:0] STAT_IDLE = 2'b00;
  localparam logic [1:0] STAT_A    = 2'b01;
  localparam logic [1:0] STAT_AB   = 2'b10;
  localparam logic [1:0] STAT_PEND = 2'b11;
endpackage

// File: rtl/dbgseq_rst_sync.sv
module dbgseq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], 1'b1};
  end

  assign rst_q = chain[STAGES-1];
endmodule

// File: rtl/dbgseq_classify.sv
module dbgseq_classify
  import dbgseq_pkg::*;
#(
  parameter int         CFG_W      = 3,
  parameter int         TAG_W      = 2,
  parameter logic [2:0] DEBUG_CODE = 3'b111
) (
  input  logic             match_vld,
  input  logic [CFG_W-1:0] match_cfg,
  input  logic [TAG_W-1:0] match_tag,
  output logic             dbg_hit,
  output logic             hit_a,
  output logic             hit_b,
  output logic             hit_c
);
  always_comb begin
    dbg_hit = match_vld && (match_cfg == CFG_W'(DEBUG_CODE));
    hit_a   = dbg_hit && (match_tag == TAG_W'(TAG_A));
    hit_b   = dbg_hit && (match_tag == TAG_W'(TAG_B));
    hit_c   = dbg_hit && (match_tag == TAG_W'(TAG_C));
  end
endmodule

// File: rtl/dbgseq_fsm.sv
module dbgseq_fsm
  import dbgseq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_q,
  input  logic       dbg_hit,
  input  logic       hit_a,
  input  logic       hit_b,
  input  logic       hit_c,
  input  logic       store_done,
  input  logic       dma_ack,
  output logic       accept,
  output logic       dma_req,
  output logic [1:0] status
);
  seq_state_t state_q, state_d;

  always_comb begin
    state_d = state_q;
    accept  = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (hit_a) begin
          accept  = 1'b1;
          state_d = ST_HAVEA;
        end
      end
      ST_HAVEA: begin
        if (hit_a) begin
          accept  = 1'b1;
          state_d = ST_HAVEA;
        end else if (hit_b) begin
          accept  = 1'b1;
          state_d = ST_HAVEB;
        end else if (hit_c) begin
          state_d = ST_IDLE;
        end
      end
      ST_HAVEB: begin
        if (hit_a) begin
          accept  = 1'b1;
          state_d = ST_HAVEA;
        end else if (hit_c) begin
          accept  = 1'b1;
          state_d = ST_CWAIT;
        end else if (hit_b) begin
          state_d = ST_IDLE;
        end
      end
      ST_CWAIT: begin
        if (store_done) state_d = ST_PEND;
      end
      ST_PEND: begin
        if (dma_ack) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_comb begin
    dma_req = (state_q == ST_PEND);
    case (state_q)
      ST_HAVEA: status = STAT_A;
      ST_HAVEB,
      ST_CWAIT: status = STAT_AB;
      ST_PEND:  status = STAT_PEND;
      default:  status = STAT_IDLE;
    endcase
  end

  // R5
  pend_from_cwait_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (state_q == ST_PEND && $past(state_q) != ST_PEND) |-> $past(state_q == ST_CWAIT && store_done));

  // R6
  cwait_no_accept_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (state_q == ST_CWAIT && dbg_hit) |=> (state_q != ST_IDLE && state_q != ST_HAVEA));
endmodule

// File: rtl/dbgseq_store.sv
module dbgseq_store #(
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst_q,
  input  logic             accept,
  input  logic [IDX_W-1:0] match_idx,
  output logic             store_en,
  output logic [IDX_W-1:0] store_idx
);
  logic             en_d;
  logic [IDX_W-1:0] idx_d;

  always_comb begin
    en_d  = accept;
    idx_d = store_idx;
    if (accept) idx_d = match_idx;
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      store_en  <= 1'b0;
      store_idx <= '0;
    end else begin
      store_en  <= en_d;
      store_idx <= idx_d;
    end
  end
endmodule

// File: rtl/dbgseq_top.sv
module dbgseq_top
  import dbgseq_pkg::*;
#(
  parameter int         IDX_W      = 6,
  parameter int         CFG_W      = 3,
  parameter int         TAG_W      = 2,
  parameter logic [2:0] DEBUG_CODE = 3'b111,
  parameter int         SYNC_STG   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             match_vld,
  input  logic [CFG_W-1:0] match_cfg,
  input  logic [TAG_W-1:0] match_tag,
  input  logic [IDX_W-1:0] match_idx,
  input  logic             store_done,
  input  logic             dma_ack,
  output logic             store_en,
  output logic [IDX_W-1:0] store_idx,
  output logic             new_data_set,
  output logic             rx_irq_set,
  output logic             dma_req,
  output logic [1:0]       dbg_status
);
  logic rst_q;
  logic dbg_hit, hit_a, hit_b, hit_c;
  logic accept;

  dbgseq_rst_sync #(.STAGES(SYNC_STG)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_q(rst_q)
  );

  dbgseq_classify #(.CFG_W(CFG_W), .TAG_W(TAG_W), .DEBUG_CODE(DEBUG_CODE)) u_cls (
    .match_vld(match_vld), .match_cfg(match_cfg), .match_tag(match_tag),
    .dbg_hit(dbg_hit), .hit_a(hit_a), .hit_b(hit_b), .hit_c(hit_c)
  );

  dbgseq_fsm u_fsm (
    .clk(clk), .rst_q(rst_q), .dbg_hit(dbg_hit),
    .hit_a(hit_a), .hit_b(hit_b), .hit_c(hit_c),
    .store_done(store_done), .dma_ack(dma_ack),
    .accept(accept), .dma_req(dma_req), .status(dbg_status)
  );

  dbgseq_store #(.IDX_W(IDX_W)) u_st (
    .clk(clk), .rst_q(rst_q), .accept(accept), .match_idx(match_idx),
    .store_en(store_en), .store_idx(store_idx)
  );

  // Debug stores never flag new data or raise the buffer interrupt.
  assign new_data_set = 1'b0;
  assign rx_irq_set   = 1'b0;

  // R2
  store_needs_debug_chk: assert property (@(posedge clk) disable iff (!rst_q)
    store_en |-> $past(match_vld && match_cfg == CFG_W'(DEBUG_CODE)));

  // R6
  pend_blocks_store_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (dma_req && match_vld) |=> !store_en);

  // R5
  req_rise_chk: assert property (@(posedge clk) disable iff (!rst_q)
    $rose(dma_req) |-> $past(store_done));

  // R7
  req_fall_chk: assert property (@(posedge clk) disable iff (!rst_q)
    $fell(dma_req) |-> $past(dma_ack));

  // R3
  store_idx_chk: assert property (@(posedge clk) disable iff (!rst_q)
    store_en |-> (store_idx == $past(match_idx)));
endmodule

// File: tb/dbgseq_top_test.sv
module dbgseq_top_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       match_vld;
  logic [2:0] match_cfg;
  logic [1:0] match_tag;
  logic [5:0] match_idx;
  logic       store_done;
  logic       dma_ack;
  logic       store_en;
  logic [5:0] store_idx;
  logic       new_data_set, rx_irq_set, dma_req;
  logic [1:0] dbg_status;

  int n_chk = 0;
  int n_bad = 0;
  int phase = 0;            // 0 idle, 1 A, 2 AB, 3 C write open, 4 pending
  logic       e_en = 1'b0;
  logic [5:0] e_idx = 6'd0;

  always #2 clk = ~clk;

  dbgseq_top uut (
    .clk(clk), .rst_n(rst_n), .match_vld(match_vld), .match_cfg(match_cfg),
    .match_tag(match_tag), .match_idx(match_idx), .store_done(store_done),
    .dma_ack(dma_ack), .store_en(store_en), .store_idx(store_idx),
    .new_data_set(new_data_set), .rx_irq_set(rx_irq_set), .dma_req(dma_req),
    .dbg_status(dbg_status)
  );

  initial begin
    #400000;
    n_bad++;
    $display("FAIL watchdog: run did not finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  function automatic logic [1:0] stat_of(int p);
    if (p == 1) return 2'b01;
    if (p == 2 || p == 3) return 2'b10;
    if (p == 4) return 2'b11;
    return 2'b00;
  endfunction

  task automatic compare(string tag);
    n_chk++;
    if (store_en !== e_en || (e_en && store_idx !== e_idx) ||
        dma_req !== (phase == 4) || dbg_status !== stat_of(phase) ||
        new_data_set !== 1'b0 || rx_irq_set !== 1'b0) begin
      n_bad++;
      $display("FAIL %s: en=%b idx=%0d req=%b st=%b nd=%b irq=%b exp en=%b idx=%0d req=%b st=%b nd=0 irq=0",
               tag, store_en, store_idx, dma_req, dbg_status, new_data_set, rx_irq_set,
               e_en, e_idx, phase == 4, stat_of(phase));
    end
  endtask

  // one cycle: drive at negedge, model at posedge, compare at next negedge
  task automatic cyc(string tag, logic v, logic [2:0] cfg, logic [1:0] tg,
                     logic [5:0] idx, logic sd, logic ack);
    bit dbg;
    match_vld = v; match_cfg = cfg; match_tag = tg; match_idx = idx;
    store_done = sd; dma_ack = ack;
    @(posedge clk);
    dbg  = v && cfg == 3'b111;
    e_en = 1'b0;
    if (phase <= 2 && dbg) begin
      if (tg == 2'b00) begin e_en = 1'b1; e_idx = idx; phase = 1; end
      else if (tg == 2'b01) begin
        if (phase == 1) begin e_en = 1'b1; e_idx = idx; phase = 2; end
        else phase = 0;
      end else if (tg == 2'b10) begin
        if (phase == 2) begin e_en = 1'b1; e_idx = idx; phase = 3; end
        else phase = 0;
      end
    end else if (phase == 3) begin
      if (sd) phase = 4;
    end else if (phase == 4) begin
      if (ack) phase = 0;
    end
    @(negedge clk);
    compare(tag);
  endtask

  task automatic idle(string tag, int n);
    for (int i = 0; i < n; i++) cyc(tag, 0, 3'b111, 2'b00, 6'd0, 0, 0);
  endtask

  task automatic msg(string tag, logic [1:0] tg, logic [5:0] idx);
    cyc(tag, 1, 3'b111, tg, idx, 0, 0);
  endtask

  initial begin
    rst_n = 1'b0; match_vld = 0; match_cfg = 0; match_tag = 0; match_idx = 0;
    store_done = 0; dma_ack = 0;
    repeat (3) @(negedge clk);
    compare("R1 in reset");
    rst_n = 1'b1;
    idle("R1 after release", 3);

    // R2: non-debug codes ignored
    for (int c = 0; c < 7; c++) cyc("R2 non-debug code", 1, 3'(c), 2'b00, 6'd5, 0, 0);
    idle("R2", 1);

    // R7: ack while idle ignored; R5: store_done while idle ignored
    cyc("R7 stray ack", 0, 3'b111, 2'b00, 6'd0, 0, 1);
    cyc("R5 stray done", 0, 3'b111, 2'b00, 6'd0, 1, 0);

    // R3 R4 R5 R6 R7 R10: full set
    msg("R3 msg A", 2'b00, 6'd61);
    idle("R3", 1);
    msg("R4 msg B", 2'b01, 6'd62);
    msg("R4 msg C", 2'b10, 6'd63);
    msg("R6 match during C write", 2'b00, 6'd9);
    cyc("R6 done w/ ack", 0, 3'b111, 2'b00, 6'd0, 0, 1);
    cyc("R5 done", 0, 3'b111, 2'b00, 6'd0, 1, 0);
    msg("R6 A while pending", 2'b00, 6'd10);
    msg("R6 C while pending", 2'b10, 6'd11);
    idle("R6 hold", 3);
    cyc("R7 ack", 0, 3'b111, 2'b00, 6'd0, 0, 1);
    idle("R7 idle", 2);

    // R8: repeated A, A after AB
    msg("R8 A", 2'b00, 6'd1);
    msg("R8 A again", 2'b00, 6'd2);
    msg("R8 B", 2'b01, 6'd3);
    msg("R8 A after AB", 2'b00, 6'd4);

    // R9: out-of-order B/C, tag 11
    msg("R9 C after A", 2'b10, 6'd5);
    msg("R9 B from idle", 2'b01, 6'd6);
    msg("R9 C from idle", 2'b10, 6'd7);
    msg("R9 A", 2'b00, 6'd8);
    msg("R9 tag11", 2'b11, 6'd9);
    msg("R9 B", 2'b01, 6'd10);
    msg("R9 B twice", 2'b01, 6'd11);
    msg("R9 A", 2'b00, 6'd12);
    msg("R9 B", 2'b01, 6'd13);
    cyc("R2 non-debug C", 1, 3'b011, 2'b10, 6'd14, 0, 0);
    msg("R4 C", 2'b10, 6'd15);
    idle("R4 wait", 2);
    cyc("R5 done", 0, 3'b111, 2'b00, 6'd0, 1, 0);
    cyc("R7 ack", 0, 3'b111, 2'b00, 6'd0, 0, 1);

    // back-to-back set with done/ack on consecutive cycles
    msg("R3 A2", 2'b00, 6'd20);
    msg("R4 B2", 2'b01, 6'd21);
    msg("R4 C2", 2'b10, 6'd22);
    cyc("R5 done2", 0, 3'b111, 2'b00, 6'd0, 1, 0);
    cyc("R7 ack2 + A", 1, 3'b111, 2'b00, 6'd30, 0, 1);
    msg("R3 A after ack", 2'b00, 6'd31);
    idle("R10 tail", 3);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule